// File: doc/BRIEF.md
# Micro Translation Lookaside Cache

This block keeps a handful of recently used virtual-to-physical page translations so that most accesses avoid a trip through the main TLB. It has two independent, fully associative arrays: one serves instruction fetches, the other serves data accesses. A lookup presents a virtual address, whether the access is a fetch, and whether it is a write. The block answers in the same cycle with a hit flag, the physical address and the permission level of the matching entry.

Once the main TLB has translated a page, the result is written into the array for that access type. The write carries a permission level derived from the page's dirty bit and takes effect on the next clock edge. The directly mapped kernel window never looks in the cache. A bypass input turns the block off for both lookup and fill, and an invalidate input empties both arrays in a single cycle.

Top module: `utlb_cache`

## Requirements
- R1: Entries are tagged by the virtual page number, which is the virtual address shifted right by 12. On a hit, `lk_paddr` is the stored physical page number placed above bits [11:0] of `lk_vaddr`, and `lk_level` is the level stored in the entry.
- R2: A lookup with `lk_is_instr`=1 searches only the instruction array, and a lookup with `lk_is_instr`=0 searches only the data array. A fill with `fl_is_instr`=1 writes only the instruction array, and a fill with `fl_is_instr`=0 writes only the data array.
- R3: The level encodings are 1 for read-only and 2 for read/write. A read hits an entry of level 1 or 2. A write hits only an entry of level 2.
- R4: A lookup whose `lk_vaddr`[31:30] is 2'b10 never hits. Addresses outside that window are looked up normally, including those with bits [31:30] = 2'b11.
- R5: A fill with `fl_valid`=1 stores level 2 when `fl_dirty`=1 and level 1 otherwise. The fill is registered: a lookup made in the same cycle as the fill sees the array contents from before the fill, and the new entry is visible from the next cycle.
- R6: While `bypass_en`=1, no lookup hits and no fill is stored.
- R7: Each array holds 4 entries. A fill of a new page goes to the entry selected by a round-robin pointer, which starts at entry 0 after reset or invalidate and advances by one, wrapping, only when a new page is allocated. The fifth distinct page evicts the first page.
- R8: A fill whose page number is already valid in the target array overwrites that entry, changing its physical page and level. It does not allocate a second entry and does not move the pointer.
- R9: `inval_all`=1 clears every entry of both arrays at the next edge. A fill in the same cycle is dropped.
- R10: After reset no lookup hits. On any miss, `lk_paddr` is 0 and `lk_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Disables lookup and fill |
| inval_all | input | 1 | Clears both arrays |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| lk_is_write | input | 1 | 1 = write intent, 0 = read |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | PA_W | Translated physical address (0 on miss) |
| lk_level | output | 2 | Permission level of the hit entry (0 on miss) |
| fl_valid | input | 1 | Fill request |
| fl_is_instr | input | 1 | Fill target: 1 = instruction array, 0 = data array |
| fl_vaddr | input | VA_W | Virtual address of the translated page |
| fl_ppn | input | PA_W-12 | Physical page number of the translation |
| fl_dirty | input | 1 | Dirty bit of the page: 1 stores read/write, 0 read-only |

## Verification
Two events can fall in the same cycle: a combinational lookup and a registered fill of the same page, and also a fill and a global invalidate. The bench provokes both with directed steps and again at random. It lets the lookup and the fill target the same page, and sometimes raises invalidate with a fill pending. The bench model judges the lookup against the contents from before the edge, applies the fill only afterwards, and has invalidate take priority. Later probes then show whether the page appeared or stayed absent.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_RO   = 2'd1;
  localparam logic [1:0] LVL_RW   = 2'd2;

  function automatic logic [1:0] level_from_dirty(input logic dirty);
    return dirty ? LVL_RW : LVL_RO;
  endfunction
endpackage

// File: rtl/utlb_rr_ptr.sv
module utlb_rr_ptr #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (adv) begin
      if (ptr == IDX_W'(ENTRIES - 1)) ptr <= '0;
      else                            ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/utlb_array.sv
module utlb_array #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_lvl,
  input  logic [VPN_W-1:0] rd_vpn,
  input  logic [1:0]       rd_need,
  output logic             rd_hit,
  output logic [PPN_W-1:0] rd_ppn,
  output logic [1:0]       rd_lvl
);
  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [1:0]       lvl_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ENTRIES-1:0] rd_match;
  logic [ENTRIES-1:0] wr_match;
  logic [IDX_W-1:0]   rr_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               wr_found;
  logic               do_wr;

  // Per-entry comparators
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign rd_match[e] = vld_q[e] && (tag_q[e] == rd_vpn) && (lvl_q[e] >= rd_need);
    assign wr_match[e] = vld_q[e] && (tag_q[e] == wr_vpn);
  end

  // Read mux: at most one entry per page exists, so OR-combine is exact
  always_comb begin
    rd_ppn = '0;
    rd_lvl = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (rd_match[e]) begin
        rd_ppn = rd_ppn | ppn_q[e];
        rd_lvl = rd_lvl | lvl_q[e];
      end
    end
  end
  assign rd_hit = |rd_match;

  // Victim selection: existing page first, otherwise round-robin slot
  always_comb begin
    wr_found = 1'b0;
    wr_idx   = rr_idx;
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_match[e]) begin
        wr_found = 1'b1;
        wr_idx   = IDX_W'(e);
      end
    end
  end

  assign do_wr = wr_en && !clr;

  utlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .adv (do_wr && !wr_found),
    .ptr (rr_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q <= '0;
    end else if (do_wr) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // Payload storage carries no reset
  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
      lvl_q[wr_idx] <= wr_lvl;
    end
  end
endmodule

// File: rtl/utlb_cache.sv
module utlb_cache #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 4,
  localparam int OFS_W  = utlb_pkg::PAGE_SHIFT,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass_en,
  input  logic             inval_all,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_is_instr,
  input  logic             lk_is_write,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [1:0]       lk_level,
  input  logic             fl_valid,
  input  logic             fl_is_instr,
  input  logic [VA_W-1:0]  fl_vaddr,
  input  logic [PPN_W-1:0] fl_ppn,
  input  logic             fl_dirty
);
  import utlb_pkg::*;

  localparam int NARR  = 2;  // 0 = instruction, 1 = data
  localparam int A_INS = 0;
  localparam int A_DAT = 1;

  logic [NARR-1:0]             arr_hit;
  logic [NARR-1:0][PPN_W-1:0]  arr_ppn;
  logic [NARR-1:0][1:0]        arr_lvl;

  logic       in_kwin;
  logic       lk_active;
  logic [1:0] need;
  logic       sel_hit;
  logic [PPN_W-1:0] sel_ppn;
  logic [1:0] sel_lvl;

  assign in_kwin   = (lk_vaddr[VA_W-1:VA_W-2] == 2'b10);
  assign lk_active = !bypass_en && !in_kwin;
  assign need      = lk_is_write ? LVL_RW : LVL_RO;

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    logic wr_sel;
    assign wr_sel = fl_valid && !bypass_en && (fl_is_instr == (a == A_INS));

    utlb_array #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
    ) u_arr (
      .clk     (clk),
      .rst     (rst),
      .clr     (inval_all),
      .wr_en   (wr_sel),
      .wr_vpn  (fl_vaddr[VA_W-1:OFS_W]),
      .wr_ppn  (fl_ppn),
      .wr_lvl  (level_from_dirty(fl_dirty)),
      .rd_vpn  (lk_vaddr[VA_W-1:OFS_W]),
      .rd_need (need),
      .rd_hit  (arr_hit[a]),
      .rd_ppn  (arr_ppn[a]),
      .rd_lvl  (arr_lvl[a])
    );
  end

  always_comb begin
    if (lk_is_instr) begin
      sel_hit = arr_hit[A_INS];
      sel_ppn = arr_ppn[A_INS];
      sel_lvl = arr_lvl[A_INS];
    end else begin
      sel_hit = arr_hit[A_DAT];
      sel_ppn = arr_ppn[A_DAT];
      sel_lvl = arr_lvl[A_DAT];
    end
  end

  assign lk_hit   = lk_active && sel_hit;
  assign lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_level = lk_hit ? sel_lvl : LVL_NONE;
endmodule

// File: rtl/utlb_cache_chk.sv
module utlb_cache_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bypass_en,
  input logic            inval_all,
  input logic [VA_W-1:0] lk_vaddr,
  input logic            lk_is_write,
  input logic            lk_hit,
  input logic [PA_W-1:0] lk_paddr,
  input logic [1:0]      lk_level
);
  // R4
  kwin_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_vaddr[VA_W-1:VA_W-2] == 2'b10) |-> !lk_hit);

  // R6
  bypass_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    bypass_en |-> !lk_hit);

  // R3
  write_level_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_is_write) |-> (lk_level == 2'd2));

  // R3
  hit_level_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_level == 2'd1 || lk_level == 2'd2));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

  // R9
  inval_empty_chk: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> !lk_hit);

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == '0 && lk_level == 2'd0));
endmodule

bind utlb_cache utlb_cache_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bypass_en   (bypass_en),
  .inval_all   (inval_all),
  .lk_vaddr    (lk_vaddr),
  .lk_is_write (lk_is_write),
  .lk_hit      (lk_hit),
  .lk_paddr    (lk_paddr),
  .lk_level    (lk_level)
);

// File: tb/tb_utlb_cache.sv
`timescale 1ns/1ps
module tb_utlb_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bypass_en = 1'b0;
  logic        inval_all = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_is_instr = 1'b0;
  logic        lk_is_write = 1'b0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_level;
  logic        fl_valid = 1'b0;
  logic        fl_is_instr = 1'b0;
  logic [31:0] fl_vaddr = '0;
  logic [19:0] fl_ppn = '0;
  logic        fl_dirty = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  utlb_cache dut (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .inval_all(inval_all),
    .lk_vaddr(lk_vaddr), .lk_is_instr(lk_is_instr), .lk_is_write(lk_is_write),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_level(lk_level),
    .fl_valid(fl_valid), .fl_is_instr(fl_is_instr), .fl_vaddr(fl_vaddr),
    .fl_ppn(fl_ppn), .fl_dirty(fl_dirty)
  );

  // Reference model, index 0 = instruction array, 1 = data array
  logic [19:0] m_tag [2][4];
  logic [19:0] m_ppn [2][4];
  logic [1:0]  m_lvl [2][4];
  bit          m_vld [2][4];
  int          m_ptr [2];

  task automatic model_clear();
    for (int a = 0; a < 2; a++) begin
      for (int e = 0; e < 4; e++) m_vld[a][e] = 0;
      m_ptr[a] = 0;
    end
  endtask

  function automatic logic [34:0] model_lookup(input logic [31:0] va, input logic ins,
                                               input logic wr, input logic byp);
    int a;
    logic [1:0] need;
    a = ins ? 0 : 1;
    need = wr ? 2'd2 : 2'd1;
    if (byp || va[31:30] == 2'b10) return '0;
    for (int e = 0; e < 4; e++)
      if (m_vld[a][e] && m_tag[a][e] == va[31:12] && m_lvl[a][e] >= need)
        return {1'b1, m_lvl[a][e], m_ppn[a][e], va[11:0]};
    return '0;
  endfunction

  task automatic model_edge(input logic byp, input logic inv, input logic fv,
                            input logic fi, input logic [31:0] fva,
                            input logic [19:0] fp, input logic fd);
    int a, idx;
    if (inv) begin
      model_clear();
      return;
    end
    if (!fv || byp) return;
    a = fi ? 0 : 1;
    idx = -1;
    for (int e = 0; e < 4; e++)
      if (m_vld[a][e] && m_tag[a][e] == fva[31:12]) idx = e;
    if (idx < 0) begin
      idx = m_ptr[a];
      m_ptr[a] = (m_ptr[a] + 1) % 4;
    end
    m_vld[a][idx] = 1;
    m_tag[a][idx] = fva[31:12];
    m_ppn[a][idx] = fp;
    m_lvl[a][idx] = fd ? 2'd2 : 2'd1;
  endtask

  task automatic compare(input string tag, input logic [34:0] got, input logic [34:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got hit=%0d lvl=%0d pa=%08h expected hit=%0d lvl=%0d pa=%08h",
               tag, got[34], got[33:32], got[31:0], exp[34], exp[33:32], exp[31:0]);
    end
  endtask

  // One cycle: lookup checked against pre-edge model, then fill/invalidate applied
  task automatic step(input string tag, input logic [31:0] va, input logic ins,
                      input logic wr, input logic byp, input logic inv,
                      input logic fv, input logic fi, input logic [31:0] fva,
                      input logic [19:0] fp, input logic fd);
    @(negedge clk);
    lk_vaddr = va; lk_is_instr = ins; lk_is_write = wr;
    bypass_en = byp; inval_all = inv;
    fl_valid = fv; fl_is_instr = fi; fl_vaddr = fva; fl_ppn = fp; fl_dirty = fd;
    #1;
    compare(tag, {lk_hit, lk_level, lk_paddr}, model_lookup(va, ins, wr, byp));
    @(posedge clk);
    model_edge(byp, inv, fv, fi, fva, fp, fd);
  endtask

  task automatic fill(input string tag, input logic fi, input logic [31:0] fva,
                      input logic [19:0] fp, input logic fd);
    step(tag, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, fi, fva, fp, fd);
  endtask

  // Directed probe against constant expectations, no fill
  task automatic probe(input string tag, input logic [31:0] va, input logic ins,
                       input logic wr, input logic byp, input logic eh,
                       input logic [31:0] epa, input logic [1:0] el);
    @(negedge clk);
    lk_vaddr = va; lk_is_instr = ins; lk_is_write = wr;
    bypass_en = byp; inval_all = 1'b0; fl_valid = 1'b0;
    #1;
    compare(tag, {lk_hit, lk_level, lk_paddr}, {eh, el, epa});
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, fva;
    void'($urandom(32'd20240611));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    probe("R10 reset", 32'h0040_0123, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    probe("R10 reset instr", 32'h0040_0123, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);

    // R5 lookup and fill of the same page in one cycle
    step("R5 same-cycle", 32'h0040_0123, 1'b0, 1'b0, 1'b0, 1'b0,
         1'b1, 1'b0, 32'h0040_0000, 20'h12345, 1'b0);
    probe("R5 R1 clean read", 32'h0040_0123, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5123, 2'd1);
    probe("R3 write on ro", 32'h0040_0123, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 2'd0);
    fill("R5 dirty fill", 1'b0, 32'h0040_1000, 20'h0AAAA, 1'b1);
    probe("R5 R3 dirty write", 32'h0040_1fff, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0AAA_Afff, 2'd2);
    probe("R3 read on rw", 32'h0040_1000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0AAA_A000, 2'd2);

    // R2 separate arrays
    probe("R2 instr empty", 32'h0040_0123, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    fill("R2 instr fill", 1'b1, 32'h0040_0000, 20'h55555, 1'b0);
    probe("R2 instr hit", 32'h0040_0abc, 1'b1, 1'b0, 1'b0, 1'b1, 32'h5555_5abc, 2'd1);
    probe("R2 data kept", 32'h0040_0abc, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5abc, 2'd1);

    // R8 overwrite of existing page (data: e0=400, e1=401, ptr=2)
    fill("R8 refill", 1'b0, 32'h0040_0000, 20'h22222, 1'b1);
    probe("R8 new value", 32'h0040_0123, 1'b0, 1'b1, 1'b0, 1'b1, 32'h2222_2123, 2'd2);
    probe("R8 neighbour kept", 32'h0040_1004, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0AAA_A004, 2'd2);

    // R7 round-robin eviction
    fill("R7 fill 402", 1'b0, 32'h0040_2000, 20'h00502, 1'b0);
    fill("R7 fill 403", 1'b0, 32'h0040_3000, 20'h00503, 1'b0);
    fill("R7 fill 404", 1'b0, 32'h0040_4000, 20'h00504, 1'b0);
    probe("R7 first evicted", 32'h0040_0010, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    probe("R7 second kept", 32'h0040_1010, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0AAA_A010, 2'd2);
    probe("R7 newest", 32'h0040_4010, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0050_4010, 2'd1);
    fill("R7 fill 405", 1'b0, 32'h0040_5000, 20'h00505, 1'b1);
    probe("R7 second evicted", 32'h0040_1010, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    probe("R7 third kept", 32'h0040_2010, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0050_2010, 2'd1);

    // R4 kernel window never hits, 2'b11 region still does
    fill("R4 kwin fill", 1'b0, 32'h8000_1000, 20'h00777, 1'b1);
    probe("R4 kwin miss", 32'h8000_1abc, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    fill("R4 upper fill", 1'b0, 32'hC000_1000, 20'h00888, 1'b1);
    probe("R4 upper hit", 32'hC000_1abc, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0088_8abc, 2'd2);

    // R6 bypass
    probe("R6 no bypass hit", 32'h0040_5008, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0050_5008, 2'd2);
    probe("R6 bypass lookup", 32'h0040_5008, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 2'd0);
    step("R6 bypass fill", 32'h0040_5008, 1'b0, 1'b0, 1'b1, 1'b0,
         1'b1, 1'b0, 32'h0040_6000, 20'h00506, 1'b1);
    probe("R6 bypass fill dropped", 32'h0040_6000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);

    // R9 invalidate with simultaneous fill
    step("R9 inval+fill", 32'h0040_5008, 1'b0, 1'b0, 1'b0, 1'b1,
         1'b1, 1'b0, 32'h0040_7000, 20'h00507, 1'b1);
    probe("R9 fill dropped", 32'h0040_7000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    probe("R9 data cleared", 32'h0040_5008, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);
    probe("R9 instr cleared", 32'h0040_0abc, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0);

    // Random phase checked against the model (R1 R2 R3 R5 R7 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      logic byp, inv, fv;
      va  = {(($urandom % 8) == 0) ? 20'h80000 + 20'($urandom % 4)
                                   : 20'h00400 + 20'($urandom % 8), 12'($urandom)};
      fva = {20'h00400 + 20'($urandom % 8), 12'h0};
      byp = ($urandom % 16) == 0;
      inv = ($urandom % 64) == 0;
      fv  = ($urandom % 3) == 0;
      step("R7 R8 random", va, 1'($urandom), 1'($urandom), byp, inv,
           fv, 1'($urandom), fva, 20'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule